// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

This block is a purely combinational 32-bit datapath unit. It holds three engines: an adder that also subtracts, a bitwise logic unit and a multistage barrel shifter. Eight control bits choose the result. Two bits pick the operation class. One bit picks add or subtract. Three bits steer the shifter. Two bits pick the logic function. The adder's carry-out and signed overflow are always visible on their own ports, whatever the class.

Subtraction reuses the same adder: operand `y` is inverted and the carry-in is forced to 1. The shifter always moves operand `y`. The distance is either the 5-bit constant field `shamt` or the low five bits of operand `x`. The shifter is built as five fixed stages of 1, 2, 4, 8 and 16 positions, each enabled by one bit of the distance. Right shifts fill the vacated positions either with zeros or with copies of the sign bit.

The unit has no clock and no state, so the house-style state machine does not apply. Naming and layout follow the house style; there are no states or transitions to list.

Top module: `alu_multifunc`

## Requirements
- R1: With class `fclass`=2'b10 and `sub`=0, `result` equals (x + y) mod 2^32 and `carry_out` is bit 32 of the unsigned 33-bit sum.
- R2: With class 2'b10 and `sub`=1, `result` equals x + ~y + 1 mod 2^32, and `carry_out` is bit 32 of that 33-bit sum (1 when no borrow occurs).
- R3: `overflow` is 1 exactly when the two adder inputs (x and y, or x and ~y when subtracting) share a sign and the 32-bit sum has the other sign.
- R4: With class 2'b11, `lsel` picks the logic function: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR of x and y.
- R5: With class 2'b00, the result is y shifted. `shctl[0]`=0 shifts left and `shctl[0]`=1 shifts right. A logical shift fills the vacated positions with zeros.
- R6: `shctl[1]`=1 on a right shift fills the vacated positions with y[31]. `shctl[1]` has no effect on a left shift.
- R7: The shift distance is `shamt` when `shctl[2]`=0 and x[4:0] when `shctl[2]`=1. Bits x[31:5] have no effect on the shift result.
- R8: A shift distance of 0 returns y unchanged in every shift mode. A distance of 31 moves y[0] into bit 31 on a left shift and y[31] into bit 0 on a right shift.
- R9: Class 2'b01 drives `result` to zero.
- R10: `carry_out` and `overflow` always reflect the add or subtract selected by `sub`, in every class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 32 | First operand; its low 5 bits give the variable shift distance |
| y | input | 32 | Second operand; this is the data that the shifter moves |
| shamt | input | 5 | Constant shift distance |
| fclass | input | 2 | Operation class: 00 shift, 01 zero, 10 arithmetic, 11 logic |
| sub | input | 1 | 0 adds, 1 subtracts |
| shctl | input | 3 | Bit 0 direction (1 = right), bit 1 arithmetic, bit 2 distance from x |
| lsel | input | 2 | Logic function select |
| result | output | 32 | Selected result |
| carry_out | output | 1 | Adder carry out of bit 31 |
| overflow | output | 1 | Adder signed overflow |

## Verification
Assertions are evaluated on every change of the inputs and check properties that hold for any operands:
- overflow agrees with the sign rule, worked out independently of the carry chain;
- a zero distance leaves the data unchanged;
- a nonzero distance leaves the vacated edge bit at the right fill value;
- AND and OR obey their subset relations with the operands;
- the unused class gives zero.

Exact numeric results can only be shown by the bench's scenarios, which compare against a behavioural reference. These scenarios include:
- wrap-around sums and borrows;
- shifts of 0 and 31 on negative data;
- the arithmetic bit being ignored on left shifts;
- the upper bits of x being ignored as a distance.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_ZERO  = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOR = 2'b11
    } lop_e;

    localparam int SHC_RIGHT = 0;
    localparam int SHC_ARITH = 1;
    localparam int SHC_VAR   = 2;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    assign b_eff    = sub ? ~b : b;
    assign carry[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | ((a[i] ^ b_eff[i]) & carry[i]);
    end

    assign cout = carry[WIDTH];
    assign ovf  = carry[WIDTH] ^ carry[WIDTH-1];

    // R3: overflow must agree with the sign rule on the adder inputs
    always_comb begin
        assert_ovf_sign_R3: assert (ovf ==
            ((a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1])))
            else $error("overflow disagrees with sign rule");
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] out
);
    always_comb begin
        unique case (lop_e'(sel))
            LOP_AND: out = a & b;
            LOP_OR:  out = a | b;
            LOP_XOR: out = a ^ b;
            LOP_NOR: out = ~(a | b);
            default: out = '0;
        endcase
    end

    // R4: AND result is a subset of each operand; OR result covers each operand
    always_comb begin
        if (lop_e'(sel) == LOP_AND)
            assert_and_subset_R4: assert ((out & ~a) == '0 && (out & ~b) == '0)
                else $error("AND result outside operands");
        if (lop_e'(sel) == LOP_OR)
            assert_or_cover_R4: assert ((out & a) == a && (out & b) == b)
                else $error("OR result misses operand bits");
    end
endmodule

// File: rtl/alu_barrel_shifter.sv
module alu_barrel_shifter #(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    amt,
    input  logic             right,
    input  logic             arith,
    output logic [WIDTH-1:0] dout
);
    logic             fill;
    logic [WIDTH-1:0] stg [AW+1];

    assign fill   = right & arith & din[WIDTH-1];
    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        always_comb begin
            if (!amt[k])
                stg[k+1] = stg[k];
            else if (right)
                stg[k+1] = {{SH{fill}}, stg[k][WIDTH-1:SH]};
            else
                stg[k+1] = {stg[k][WIDTH-1-SH:0], {SH{1'b0}}};
        end
    end

    assign dout = stg[AW];

    // R8: zero distance passes data through; R5/R6: vacated edge bit has fill value
    always_comb begin
        if (amt == '0)
            assert_zero_pass_R8: assert (dout == din)
                else $error("zero shift altered data");
        else if (right)
            assert_right_fill_R6: assert (dout[WIDTH-1] == (arith & din[WIDTH-1]))
                else $error("right shift fill wrong");
        else
            assert_left_fill_R5: assert (dout[0] == 1'b0)
                else $error("left shift fill wrong");
    end
endmodule

// File: rtl/alu_multifunc.sv
module alu_multifunc
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [AW-1:0]    shamt,
    input  logic [1:0]       fclass,
    input  logic             sub,
    input  logic [2:0]       shctl,
    input  logic [1:0]       lsel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);
    logic [WIDTH-1:0] add_res;
    logic [WIDTH-1:0] log_res;
    logic [WIDTH-1:0] sh_res;
    logic [AW-1:0]    sh_dist;

    assign sh_dist = shctl[SHC_VAR] ? x[AW-1:0] : shamt;

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a    (x),
        .b    (y),
        .sub  (sub),
        .sum  (add_res),
        .cout (carry_out),
        .ovf  (overflow)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a   (x),
        .b   (y),
        .sel (lsel),
        .out (log_res)
    );

    alu_barrel_shifter #(.WIDTH(WIDTH)) u_shift (
        .din   (y),
        .amt   (sh_dist),
        .right (shctl[SHC_RIGHT]),
        .arith (shctl[SHC_ARITH]),
        .dout  (sh_res)
    );

    always_comb begin
        unique case (cls_e'(fclass))
            CLS_SHIFT: result = sh_res;
            CLS_ZERO:  result = '0;
            CLS_ARITH: result = add_res;
            CLS_LOGIC: result = log_res;
            default:   result = '0;
        endcase
    end

    // R9: unused class must give zero
    always_comb begin
        if (cls_e'(fclass) == CLS_ZERO)
            assert_zero_class_R9: assert (result == '0)
                else $error("class 01 result nonzero");
    end
endmodule

// File: tb/alu_multifunc_tb.sv
`timescale 1ns/1ps
module alu_multifunc_tb;
    localparam int W = 32;
    localparam int NV = 16;
    localparam int VW = 2 + 1 + 3 + 2 + 5 + 32 + 32;

    // {fclass, sub, shctl, lsel, shamt, x, y}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b10, 1'b0, 3'b000, 2'b00, 5'd0,  32'h0000_0005, 32'h0000_0007},
        {2'b10, 1'b0, 3'b000, 2'b00, 5'd0,  32'hFFFF_FFFF, 32'h0000_0001},
        {2'b10, 1'b0, 3'b000, 2'b00, 5'd0,  32'h7FFF_FFFF, 32'h0000_0001},
        {2'b10, 1'b1, 3'b000, 2'b00, 5'd0,  32'h0000_0003, 32'h0000_0005},
        {2'b10, 1'b1, 3'b000, 2'b00, 5'd0,  32'h8000_0000, 32'h0000_0001},
        {2'b10, 1'b1, 3'b000, 2'b00, 5'd0,  32'h1234_5678, 32'h1234_5678},
        {2'b11, 1'b0, 3'b000, 2'b00, 5'd0,  32'hF0F0_AAAA, 32'hFF00_5555},
        {2'b11, 1'b0, 3'b000, 2'b01, 5'd0,  32'hF0F0_AAAA, 32'hFF00_5555},
        {2'b11, 1'b0, 3'b000, 2'b10, 5'd0,  32'hF0F0_AAAA, 32'hFF00_5555},
        {2'b11, 1'b0, 3'b000, 2'b11, 5'd0,  32'hF0F0_AAAA, 32'hFF00_5555},
        {2'b00, 1'b0, 3'b000, 2'b00, 5'd4,  32'h0000_0000, 32'h8765_4321},
        {2'b00, 1'b0, 3'b001, 2'b00, 5'd4,  32'h0000_0000, 32'h8765_4321},
        {2'b00, 1'b0, 3'b011, 2'b00, 5'd4,  32'h0000_0000, 32'h8765_4321},
        {2'b00, 1'b0, 3'b011, 2'b00, 5'd2,  32'h0000_0000, 32'h4000_0000},
        {2'b00, 1'b0, 3'b111, 2'b00, 5'd0,  32'hABCD_E007, 32'hF000_0000},
        {2'b00, 1'b0, 3'b101, 2'b00, 5'd9,  32'h0000_0013, 32'h8000_0001}
    };

    logic          clk = 1'b0;
    logic [W-1:0]  x, y, result;
    logic [4:0]    shamt;
    logic [1:0]    fclass, lsel;
    logic [2:0]    shctl;
    logic          sub, carry_out, overflow;
    int            total = 0;
    int            bad = 0;
    int            cycles = 0;

    always #2 clk = ~clk;

    alu_multifunc u_dut (
        .x(x), .y(y), .shamt(shamt), .fclass(fclass), .sub(sub),
        .shctl(shctl), .lsel(lsel), .result(result),
        .carry_out(carry_out), .overflow(overflow)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    // Behavioural reference: {carry, overflow, result}
    function automatic logic [W+1:0] ref_model(
        input logic [1:0] c, input logic s, input logic [2:0] sc,
        input logic [1:0] ls, input logic [4:0] sa,
        input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]   wide;
        logic [W-1:0] bb, r;
        logic         v;
        int           d;
        bb   = s ? ~b : b;
        wide = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, s};
        v    = (a[W-1] == bb[W-1]) && (wide[W-1] != a[W-1]);
        d    = sc[2] ? int'(a[4:0]) : int'(sa);
        case (c)
            2'b00: begin
                if (!sc[0])     r = b << d;
                else if (sc[1]) r = W'($signed(b) >>> d);
                else            r = b >> d;
            end
            2'b01: r = '0;
            2'b10: r = wide[W-1:0];
            default: begin
                case (ls)
                    2'b00: r = a & b;
                    2'b01: r = a | b;
                    2'b10: r = a ^ b;
                    default: r = ~(a | b);
                endcase
            end
        endcase
        return {wide[W], v, r};
    endfunction

    task automatic apply_and_check(
        input logic [1:0] c, input logic s, input logic [2:0] sc,
        input logic [1:0] ls, input logic [4:0] sa,
        input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W+1:0] e;
        @(negedge clk);
        fclass = c; sub = s; shctl = sc; lsel = ls; shamt = sa; x = a; y = b;
        #1;
        e = ref_model(c, s, sc, ls, sa, a, b);
        total++;
        if ({carry_out, overflow, result} !== e) begin
            bad++;
            $display("FAIL %s: actual=%h/%b/%b expected=%h/%b/%b", req,
                     result, carry_out, overflow, e[W-1:0], e[W+1], e[W]);
        end
    endtask

    function automatic string tag_of(input logic [1:0] c, input logic s,
                                     input logic [2:0] sc);
        if (c == 2'b10) return s ? "R2/R3" : "R1/R3";
        if (c == 2'b11) return "R4/R10";
        if (c == 2'b01) return "R9";
        if (sc[2]) return "R7";
        if (sc[0] && sc[1]) return "R6";
        return "R5";
    endfunction

    initial begin
        fclass = 2'b00; sub = 1'b0; shctl = 3'b000; lsel = 2'b00;
        shamt = 5'd0; x = '0; y = '0;
        // Reset-like idle state: all-zero inputs give zero outputs
        #1;
        total++;
        if (result !== '0 || carry_out !== 1'b0 || overflow !== 1'b0) begin
            bad++;
            $display("FAIL R8 idle: actual=%h expected=0", result);
        end

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            apply_and_check(v[76:75], v[74], v[73:71], v[70:69], v[68:64],
                            v[63:32], v[31:0], tag_of(v[76:75], v[74], v[73:71]));
        end

        // R8: distance 0 on negative data in each mode
        apply_and_check(2'b00, 1'b0, 3'b000, 2'b00, 5'd0,  '0, 32'h8000_00F1, "R8 left0");
        apply_and_check(2'b00, 1'b0, 3'b011, 2'b00, 5'd0,  '0, 32'h8000_00F1, "R8 sra0");
        apply_and_check(2'b00, 1'b0, 3'b001, 2'b00, 5'd0,  '0, 32'h8000_00F1, "R8 srl0");
        // R8: distance 31 on negative data
        apply_and_check(2'b00, 1'b0, 3'b000, 2'b00, 5'd31, '0, 32'h8000_0001, "R8 left31");
        apply_and_check(2'b00, 1'b0, 3'b011, 2'b00, 5'd31, '0, 32'h8000_0000, "R8 sra31");
        apply_and_check(2'b00, 1'b0, 3'b001, 2'b00, 5'd31, '0, 32'h8000_0000, "R8 srl31");
        // R6: arithmetic bit ignored on left shift
        apply_and_check(2'b00, 1'b0, 3'b010, 2'b00, 5'd5,  '0, 32'hC000_0003, "R6 left-arith");
        // R7: upper x bits ignored, variable distance 31 arithmetic
        apply_and_check(2'b00, 1'b0, 3'b111, 2'b00, 5'd3,  32'hFFFF_FFFF, 32'h9000_0000, "R7 var31");
        apply_and_check(2'b00, 1'b0, 3'b101, 2'b00, 5'd0,  32'h7FFF_FFE1, 32'h0000_0002, "R7 upper-ignored");
        // R9: zero class, with flags still live (R10)
        apply_and_check(2'b01, 1'b0, 3'b000, 2'b00, 5'd0,  32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9/R10 zero-class");
        // R10: flags during a logic op with subtract selected
        apply_and_check(2'b11, 1'b1, 3'b000, 2'b11, 5'd0,  32'h8000_0000, 32'h0000_0001, "R10 flags-logic");
        // R3: negative overflow on add
        apply_and_check(2'b10, 1'b0, 3'b000, 2'b00, 5'd0,  32'h8000_0000, 32'h8000_0000, "R3 neg-ovf");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule